// File: doc/BRIEF.md
# I/Q Transmit Gain Scaler

This block applies one programmable gain to a pair of transmit samples, the in-phase (I) and quadrature (Q) words that travel side by side through a transmit path. The gain is a 5-bit unsigned code read as one integer bit and four fraction bits. A code of zero mutes the pair. The largest code gives a gain just short of two, in steps of one sixteenth.

Samples arrive as 12-bit words, each pair marked by a valid strobe. A format bit chooses how a word is read. When the bit is clear, the word is a signed two's-complement value. When the bit is set, the word is an unsigned value offset by half of full scale; the block converts it to signed form by inverting its top bit. Each channel's product is rounded to the nearest integer and then clipped to the signed 12-bit range.

The datapath has two register stages: the multiply first, then rounding and clipping. The scaled pair appears exactly two clock cycles after the input strobe, carrying its own valid strobe. The gain code and the format bit are taken in the same cycle as the sample they apply to, so either may change on any cycle.

Top module: `iq_gain_scaler`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `out_vld` is 0 and both `out_i` and `out_q` are 0.
- R2: For a valid input, each output equals the signed sample times `gain`/16, so the step is 0.0625. Code 0 gives an output of 0, code 16 passes the sample through unchanged, and code 31 gives a gain of 1.9375.
- R3: One gain code, the one present with the sample, scales both channels, so equal I and Q inputs always give equal I and Q outputs.
- R4: With `fmt_sb` = 0 the sample is read as two's complement. With `fmt_sb` = 1 it is read as straight binary, where 0 means -2048, 2048 means 0 and 4095 means +2047; this is the same as inverting bit 11.
- R5: The sixteenths product is rounded to the nearest integer, with ties going toward positive infinity: +0.5 gives 1, -0.5 gives 0 and 1.5 gives 2.
- R6: A rounded result above +2047 is output as +2047, and one below -2048 is output as -2048.
- R7: `out_vld` is high exactly two rising clock edges after `in_vld` was sampled high. The result uses the `gain` and `fmt_sb` values sampled on the same edge as the sample.
- R8: When `in_vld` is low, the sample, gain and format inputs are ignored. While `out_vld` is low, `out_i` and `out_q` keep the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input pair valid strobe |
| in_i | input | 12 | In-phase input sample |
| in_q | input | 12 | Quadrature input sample |
| gain | input | 5 | Unsigned gain code, 1 integer bit and 4 fraction bits |
| fmt_sb | input | 1 | Input format: 0 = two's complement, 1 = straight binary |
| out_vld | output | 1 | Output pair valid strobe |
| out_i | output | 12 | Scaled in-phase sample, two's complement |
| out_q | output | 12 | Scaled quadrature sample, two's complement |

## Verification
The assertions check several properties on every cycle:
- the two-cycle valid delay;
- the muted output for code 0;
- exact pass-through at unity gain in signed format;
- that a non-negative sample never becomes negative;
- that the outputs stay unchanged between strobes.

The rounding tie direction, clipping at both rails, the offset-binary reading and the exact arithmetic for arbitrary codes can only be shown by the bench's scenarios. These compare every output pair against an independent model, first on directed corner samples and then on a long seeded random stream.

// File: rtl/iqgs_pkg.sv
package iqgs_pkg;
    localparam int SAMPLE_W = 12;
    localparam int GAIN_W   = 5;
    localparam int FRAC_W   = 4;
    localparam int PIPE_LAT = 2;
endpackage

// File: rtl/iqgs_fmt.sv
module iqgs_fmt #(
    parameter int SW = 12
) (
    input  logic                 fmt_sb,
    input  logic [SW-1:0]        raw,
    output logic signed [SW-1:0] smp
);
    // Offset binary becomes two's complement when the top bit is flipped.
    always_comb begin
        if (fmt_sb) smp = $signed({~raw[SW-1], raw[SW-2:0]});
        else        smp = $signed(raw);
    end
endmodule

// File: rtl/iqgs_lane.sv
module iqgs_lane #(
    parameter int SW = 12,
    parameter int GW = 5,
    parameter int FW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_mul,
    input  logic                 ld_out,
    input  logic signed [SW-1:0] smp,
    input  logic [GW-1:0]        gain,
    output logic signed [SW-1:0] y
);
    localparam int PW = SW + GW;
    localparam int EW = PW + 1;
    localparam logic signed [EW-1:0] HALF = EW'(1 << (FW - 1));
    localparam logic signed [EW-1:0] MAXV = EW'((1 << (SW - 1)) - 1);
    localparam logic signed [EW-1:0] MINV = -MAXV - EW'(1);

    logic signed [EW-1:0] a_ext, g_ext, mul_full;
    logic signed [PW-1:0] prod_q;
    logic signed [EW-1:0] rnd, shf;
    logic signed [SW-1:0] y_d;

    always_comb begin
        a_ext    = EW'(smp);
        g_ext    = $signed(EW'({1'b0, gain}));
        mul_full = a_ext * g_ext;
    end

    // Stage 1: the product.
    always_ff @(posedge clk) begin
        if (!rst_n)      prod_q <= '0;
        else if (ld_mul) prod_q <= mul_full[PW-1:0];
    end

    // Round half up, then clip to the sample range.
    always_comb begin
        rnd = EW'(prod_q) + HALF;
        shf = rnd >>> FW;
        if (shf > MAXV)      y_d = MAXV[SW-1:0];
        else if (shf < MINV) y_d = MINV[SW-1:0];
        else                 y_d = shf[SW-1:0];
    end

    // Stage 2: the output register.
    always_ff @(posedge clk) begin
        if (!rst_n)      y <= '0;
        else if (ld_out) y <= y_d;
    end

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_out |=> $stable(y));
endmodule

// File: rtl/iq_gain_scaler.sv
module iq_gain_scaler
    import iqgs_pkg::*;
#(
    parameter int SW = SAMPLE_W,
    parameter int GW = GAIN_W,
    parameter int FW = FRAC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [SW-1:0] in_i,
    input  logic [SW-1:0] in_q,
    input  logic [GW-1:0] gain,
    input  logic          fmt_sb,
    output logic          out_vld,
    output logic [SW-1:0] out_i,
    output logic [SW-1:0] out_q
);
    localparam int NCH = 2;
    localparam logic [GW-1:0] UNITY = GW'(1 << FW);

    logic [SW-1:0]        raw [NCH];
    logic signed [SW-1:0] smp [NCH];
    logic signed [SW-1:0] res [NCH];
    logic [PIPE_LAT-1:0]  vpipe;

    assign raw[0] = in_i;
    assign raw[1] = in_q;

    always_ff @(posedge clk) begin
        if (!rst_n) vpipe <= '0;
        else        vpipe <= {vpipe[PIPE_LAT-2:0], in_vld};
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            iqgs_fmt #(.SW(SW)) u_fmt (
                .fmt_sb (fmt_sb),
                .raw    (raw[c]),
                .smp    (smp[c])
            );
            iqgs_lane #(.SW(SW), .GW(GW), .FW(FW)) u_lane (
                .clk    (clk),
                .rst_n  (rst_n),
                .ld_mul (in_vld),
                .ld_out (vpipe[0]),
                .smp    (smp[c]),
                .gain   (gain),
                .y      (res[c])
            );
        end
    endgenerate

    assign out_vld = vpipe[PIPE_LAT-1];
    assign out_i   = res[0];
    assign out_q   = res[1];

    // Cycles since reset, for checking windows that reach back.
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (out_vld == $past(in_vld, 2)));
    a_r2_mute: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && gain == '0) |-> ##2 (out_i == '0 && out_q == '0));
    a_r2_unity: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && gain == UNITY && !fmt_sb) |-> ##2
        (out_i == $past(in_i, 2) && out_q == $past(in_q, 2)));
    a_r6_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !fmt_sb && !in_i[SW-1]) |-> ##2 !out_i[SW-1]);
endmodule

// File: tb/iq_gain_scaler_test.sv
module iq_gain_scaler_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst_n = 0;
    logic        in_vld = 0, fmt_sb = 0;
    logic [11:0] in_i = 0, in_q = 0;
    logic [4:0]  gain = 0;
    logic        out_vld;
    logic [11:0] out_i, out_q;

    int n_chk = 0, n_bad = 0;
    logic        p0_v = 0, p1_v = 0;
    logic [11:0] p0_i = 0, p0_q = 0, p1_i = 0, p1_q = 0;
    string       p0_t = "R8", p1_t = "R8";
    logic [11:0] last_i = 0, last_q = 0;

    iq_gain_scaler uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [11:0] model(logic [11:0] x, logic [4:0] g, logic f);
        int s, r;
        if (f) s = int'(x) - 2048;
        else   s = x[11] ? int'(x) - 4096 : int'(x);
        r = (s * int'(g) + 8) >>> 4;
        if (r > 2047)  r = 2047;
        if (r < -2048) r = -2048;
        return r[11:0];
    endfunction

    task automatic chk(string tag, logic [11:0] act, logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(logic v, logic [11:0] xi, logic [11:0] xq,
                        logic [4:0] g, logic f, string tag);
        @(negedge clk);
        chk("R7 valid", {11'd0, out_vld}, {11'd0, p1_v});
        if (p1_v) begin
            chk(p1_t, out_i, p1_i);
            chk(p1_t, out_q, p1_q);
            last_i = p1_i; last_q = p1_q;
        end else begin
            chk("R8 hold", out_i, last_i);
            chk("R8 hold", out_q, last_q);
        end
        p1_v = p0_v; p1_i = p0_i; p1_q = p0_q; p1_t = p0_t;
        p0_v = v; p0_i = model(xi, g, f); p0_q = model(xq, g, f); p0_t = tag;
        in_vld = v; in_i = xi; in_q = xq; gain = g; fmt_sb = f;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [11:0] r;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R1", {11'd0, out_vld}, 12'd0);
        chk("R1", out_i, 12'd0);
        chk("R1", out_q, 12'd0);
        rst_n = 1;
        @(negedge clk);
        chk("R1", {11'd0, out_vld}, 12'd0);
        chk("R1", out_i, 12'd0);
        // directed corners
        step(1, 12'h7FF, 12'h800, 5'd31, 0, "R6 clip");
        step(1, 12'h123, 12'hABC, 5'd0,  0, "R2 mute");
        step(1, 12'h3A5, 12'hC5B, 5'd16, 0, "R2 unity");
        step(1, 12'h100, 12'hF00, 5'd31, 0, "R2 max code");
        step(1, 12'h001, 12'hFFF, 5'd8,  0, "R5 tie");
        step(1, 12'h003, 12'hFFD, 5'd8,  0, "R5 tie");
        step(0, 12'h555, 12'hAAA, 5'd31, 1, "R8");
        step(0, 12'h7FF, 12'h000, 5'd1,  0, "R8");
        step(1, 12'h000, 12'hFFF, 5'd16, 1, "R4 offset");
        step(1, 12'h800, 12'h801, 5'd16, 1, "R4 offset");
        step(1, 12'hFFF, 12'h000, 5'd31, 1, "R4 R6");
        step(1, 12'h400, 12'h400, 5'd23, 0, "R3 shared");
        step(1, 12'h9C4, 12'h9C4, 5'd9,  1, "R3 shared");
        step(1, 12'h7FF, 12'h800, 5'd16, 1, "R7 back to back");
        // seeded random stream
        for (int k = 0; k < 3000; k++) begin
            r = 12'($urandom);
            if (k % 7 == 0)
                step(1, r, r, 5'($urandom), 1'($urandom), "R3 random");
            else
                step(($urandom % 4) != 0, r, 12'($urandom), 5'($urandom),
                     1'($urandom), "R2 random");
        end
        step(0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 0, "R8");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule